// File: doc/BRIEF.md
# Image Port Output Formatter

This block sits at the output of a video capture path. It drains 32-bit dwords from two independent producers, a scaled-video stream and a stream of sliced vertical-blanking (VBI) data, and places them on a narrow output bus of 8 or 16 bits. A qualifier pin marks the cycles that carry real output. Where the receiver has no spare pin for that flag, the qualifier can instead act as a gated clock, so that only qualified cycles produce an edge.

When code insertion is enabled, each transferred line is framed by a four-byte start code and a four-byte end code, in the style of the common digital video interface. The last code byte carries field, vertical-blanking and line-phase bits, along with protection bits. With codes, the receiver needs only the data lines and one clock or gated-clock line. Codes appear only around lines that actually carry data. The line length between the codes follows whatever the producer delivers. Between dwords the bus may idle with 00H filler, but never inside a code or inside a dword.

Each line is a unit of arbitration. When both producers are waiting at a line boundary, the VBI producer wins by default, and a configuration bit reverses this. A line that has started is never preempted. A separate flag output is high while VBI data, including its framing codes, is on the bus.

Top module: `ipf_formatter`

## Requirements
- R1: In 8-bit mode (cfg_wide=0) each dword goes out as four beats on out_data[7:0], starting with bits [7:0] and ending with bits [31:24]; out_data[15:8] is 00H.
- R2: In 16-bit mode (cfg_wide=1) each dword goes out as two beats. Beat one is {bits[15:8], bits[7:0]} and beat two is {bits[31:24], bits[23:16]}, so the chroma bytes always sit on out_data[7:0] and the luma bytes on out_data[15:8].
- R3: With cfg_gate=0, out_qual is high exactly on cycles that carry a code or data beat. On every other cycle out_data is 0000H.
- R4: With cfg_gate=1, out_qual equals the clock ANDed with the qualifier, so it is low whenever the clock is low.
- R5: With cfg_codes=1, a line is sent as a start code FFH,00H,00H,XY, then its data, then an end code FFH,00H,00H,XY. In 16-bit mode each code byte appears on both lanes. With cfg_codes=0, no code is sent.
- R6: The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 to bit 0. H is 0 in the start code and 1 in the end code. F is the field bit of the line. V is vid_vblank for video lines and 1 for VBI lines.
- R7: The four beats of a code are on consecutive cycles, with no filler between them.
- R8: While no producer offers data, nothing is qualified, even with cfg_codes=1.
- R9: The number of data beats between the start and end codes equals the number of dwords the producer marks as one line (vid_last/vbi_last on the final dword). It is not a fixed count.
- R10: The source is chosen only when no line is in progress. If both are valid, VBI wins when cfg_vbi_first=1 and video wins when it is 0. A line in progress is finished before the other source is served.
- R11: out_vbi is high on every qualified beat of a VBI line, including its codes, and low on all beats of video lines.
- R12: The beats of one dword are on consecutive cycles. Filler appears only between dwords, when the producer has not offered the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects the 16-bit bus, 0 the 8-bit bus |
| cfg_codes | input | 1 | 1 frames each line with start and end codes |
| cfg_gate | input | 1 | 1 makes out_qual a gated clock |
| cfg_vbi_first | input | 1 | 1 gives VBI lines precedence at line boundaries |
| vid_valid | input | 1 | Video dword offered |
| vid_ready | output | 1 | Video dword taken this cycle |
| vid_data | input | 32 | Video dword |
| vid_last | input | 1 | Marks the final dword of a video line |
| vid_field | input | 1 | Field bit of the video line |
| vid_vblank | input | 1 | Vertical-blanking bit of the video line |
| vbi_valid | input | 1 | VBI dword offered |
| vbi_ready | output | 1 | VBI dword taken this cycle |
| vbi_data | input | 32 | VBI dword |
| vbi_last | input | 1 | Marks the final dword of a VBI line |
| vbi_field | input | 1 | Field bit of the VBI line |
| out_data | output | 16 | Output bus: chroma lane [7:0], luma lane [15:8] |
| out_qual | output | 1 | Data qualifier or gated clock |
| out_vbi | output | 1 | High while a VBI line is on the bus |

## Verification
Most of the state here is the line-sequencing state and the beat or code index. A wrong beat index shows on the very next qualified beat as a byte on the wrong lane or out of order. A lost or stuck code index shows within four beats as a missing, repeated or split code. A wrong source lock shows as foreign bytes inside a line, or as an out_vbi value that disagrees with the line, on the first beat after the start code. An end-of-line marker that is dropped shows as a missing end code and a stall of the other producer. The scoreboard catches this one line later at the latest.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAV  = 2'd1,
        ST_DATA = 2'd2,
        ST_EAV  = 2'd3
    } ipf_state_e;

    typedef enum logic {
        SRC_VID = 1'b0,
        SRC_VBI = 1'b1
    } ipf_src_e;

    // timing reference byte: marker bit, F, V, H, then four protection bits
    function automatic logic [7:0] ipf_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/ipf_arbiter.sv
module ipf_arbiter (
    input  logic vid_req,
    input  logic vbi_req,
    input  logic vbi_first,
    output logic grant,
    output logic pick_vbi
);
    always_comb begin
        grant    = vid_req | vbi_req;
        pick_vbi = vbi_req & (vbi_first | ~vid_req);
    end
endmodule

// File: rtl/ipf_code_gen.sv
module ipf_code_gen #(
    parameter int BYTE_W = 8
) (
    input  logic [1:0]          idx,
    input  logic                f,
    input  logic                v,
    input  logic                h,
    input  logic                wide,
    output logic [2*BYTE_W-1:0] lanes
);
    import ipf_pkg::*;

    logic [BYTE_W-1:0] code;

    always_comb begin
        unique case (idx)
            2'd0:    code = '1;
            2'd3:    code = BYTE_W'(ipf_xy(f, v, h));
            default: code = '0;
        endcase
        lanes = wide ? {code, code} : {{BYTE_W{1'b0}}, code};
    end
endmodule

// File: rtl/ipf_lane_mux.sv
module ipf_lane_mux #(
    parameter int DWORD_W = 32,
    parameter int BYTE_W  = 8,
    parameter int BEAT_W  = $clog2(DWORD_W / BYTE_W)
) (
    input  logic [DWORD_W-1:0]  dword,
    input  logic [BEAT_W-1:0]   beat,
    input  logic                wide,
    output logic [2*BYTE_W-1:0] lanes
);
    localparam int NB = DWORD_W / BYTE_W;

    logic [BYTE_W-1:0] bytes [NB];
    logic [BEAT_W-1:0] pair_lo;
    logic [BEAT_W-1:0] pair_hi;

    generate
        for (genvar g = 0; g < NB; g++) begin : g_split
            assign bytes[g] = dword[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        pair_lo = BEAT_W'(beat << 1);
        pair_hi = pair_lo | BEAT_W'(1);
        if (wide) lanes = {bytes[pair_hi], bytes[pair_lo]};
        else      lanes = {{BYTE_W{1'b0}}, bytes[beat]};
    end
endmodule

// File: rtl/ipf_formatter.sv
module ipf_formatter #(
    parameter int DWORD_W = 32,
    parameter int BYTE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wide,
    input  logic                cfg_codes,
    input  logic                cfg_gate,
    input  logic                cfg_vbi_first,
    input  logic                vid_valid,
    output logic                vid_ready,
    input  logic [DWORD_W-1:0]  vid_data,
    input  logic                vid_last,
    input  logic                vid_field,
    input  logic                vid_vblank,
    input  logic                vbi_valid,
    output logic                vbi_ready,
    input  logic [DWORD_W-1:0]  vbi_data,
    input  logic                vbi_last,
    input  logic                vbi_field,
    output logic [2*BYTE_W-1:0] out_data,
    output logic                out_qual,
    output logic                out_vbi
);
    import ipf_pkg::*;

    localparam int NB     = DWORD_W / BYTE_W;
    localparam int BEAT_W = $clog2(NB);
    localparam int LANE_W = 2 * BYTE_W;
    localparam logic [BEAT_W-1:0] LAST_NARROW = BEAT_W'(NB - 1);
    localparam logic [BEAT_W-1:0] LAST_WIDE   = BEAT_W'(NB / 2 - 1);

    typedef struct packed {
        ipf_state_e          state;
        ipf_src_e            src;
        logic                have;
        logic [DWORD_W-1:0]  hold;
        logic                hold_last;
        logic [BEAT_W-1:0]   beat;
        logic [1:0]          cidx;
        logic                f;
        logic                v;
        logic [LANE_W-1:0]   odata;
        logic                ovld;
        logic                ovbi;
    } fmt_s;

    fmt_s q_r, d_c;

    logic               gnt_any, gnt_vbi;
    logic               s_valid, s_last;
    logic [DWORD_W-1:0] s_data;
    logic [DWORD_W-1:0] dw_sel;
    logic [BEAT_W-1:0]  beat_sel;
    logic [BEAT_W-1:0]  last_beat;
    logic [LANE_W-1:0]  data_lanes, code_lanes;

    ipf_arbiter u_arb (
        .vid_req   (vid_valid),
        .vbi_req   (vbi_valid),
        .vbi_first (cfg_vbi_first),
        .grant     (gnt_any),
        .pick_vbi  (gnt_vbi)
    );

    ipf_lane_mux #(.DWORD_W(DWORD_W), .BYTE_W(BYTE_W), .BEAT_W(BEAT_W)) u_mux (
        .dword (dw_sel),
        .beat  (beat_sel),
        .wide  (cfg_wide),
        .lanes (data_lanes)
    );

    ipf_code_gen #(.BYTE_W(BYTE_W)) u_code (
        .idx   (q_r.cidx),
        .f     (q_r.f),
        .v     (q_r.v),
        .h     (q_r.state == ST_EAV),
        .wide  (cfg_wide),
        .lanes (code_lanes)
    );

    // source of the locked line and the dword on the lane mux
    always_comb begin
        s_valid   = (q_r.src == SRC_VBI) ? vbi_valid : vid_valid;
        s_data    = (q_r.src == SRC_VBI) ? vbi_data  : vid_data;
        s_last    = (q_r.src == SRC_VBI) ? vbi_last  : vid_last;
        dw_sel    = q_r.have ? q_r.hold : s_data;
        beat_sel  = q_r.have ? q_r.beat : '0;
        last_beat = cfg_wide ? LAST_WIDE : LAST_NARROW;
    end

    // next-state computation
    always_comb begin
        d_c       = q_r;
        d_c.odata = '0;
        d_c.ovld  = 1'b0;
        d_c.ovbi  = 1'b0;
        vid_ready = 1'b0;
        vbi_ready = 1'b0;

        unique case (q_r.state)
            ST_IDLE: begin
                if (gnt_any) begin
                    d_c.src   = gnt_vbi ? SRC_VBI : SRC_VID;
                    d_c.f     = gnt_vbi ? vbi_field : vid_field;
                    d_c.v     = gnt_vbi ? 1'b1 : vid_vblank;
                    d_c.have  = 1'b0;
                    d_c.beat  = '0;
                    d_c.cidx  = '0;
                    d_c.state = cfg_codes ? ST_SAV : ST_DATA;
                end
            end
            ST_SAV, ST_EAV: begin
                d_c.odata = code_lanes;
                d_c.ovld  = 1'b1;
                d_c.ovbi  = (q_r.src == SRC_VBI);
                d_c.cidx  = 2'(q_r.cidx + 2'd1);
                if (q_r.cidx == 2'd3)
                    d_c.state = (q_r.state == ST_SAV) ? ST_DATA : ST_IDLE;
            end
            ST_DATA: begin
                if (q_r.have) begin
                    d_c.odata = data_lanes;
                    d_c.ovld  = 1'b1;
                    d_c.ovbi  = (q_r.src == SRC_VBI);
                    if (q_r.beat == last_beat) begin
                        d_c.have = 1'b0;
                        d_c.beat = '0;
                        if (q_r.hold_last) begin
                            d_c.cidx  = '0;
                            d_c.state = cfg_codes ? ST_EAV : ST_IDLE;
                        end
                    end else begin
                        d_c.beat = BEAT_W'(q_r.beat + BEAT_W'(1));
                    end
                end else if (s_valid) begin
                    if (q_r.src == SRC_VBI) vbi_ready = 1'b1;
                    else                    vid_ready = 1'b1;
                    d_c.hold      = s_data;
                    d_c.hold_last = s_last;
                    d_c.have      = 1'b1;
                    d_c.beat      = BEAT_W'(1);
                    d_c.odata     = data_lanes;
                    d_c.ovld      = 1'b1;
                    d_c.ovbi      = (q_r.src == SRC_VBI);
                end
            end
            default: d_c.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r       <= '0;
            q_r.state <= ST_IDLE;
            q_r.src   <= SRC_VID;
        end else begin
            q_r <= d_c;
        end
    end

    always_comb begin
        out_data = q_r.odata;
        out_vbi  = q_r.ovbi;
        out_qual = cfg_gate ? (clk & q_r.ovld) : q_r.ovld;
    end

endmodule

// File: rtl/ipf_formatter_chk.sv
module ipf_formatter_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_gate,
    input logic [15:0]         out_data,
    input logic                out_qual,
    input logic                out_vbi,
    input logic                vid_ready,
    input logic                vbi_ready,
    input logic                vld,
    input ipf_pkg::ipf_state_e st,
    input logic [1:0]          cidx
);
    import ipf_pkg::*;

    // filler value on unqualified cycles
    assert_filler_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> (out_data == 16'h0000));

    assert_qual_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_gate |-> (out_qual == vld));

    // code beats follow each other without a hole
    assert_code_gapless_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_SAV) || (st == ST_EAV)) |=> vld);

    // XY byte: marker set, protection consistent, H matches code kind
    assert_xy_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(st) == ST_SAV) || ($past(st) == ST_EAV)) && ($past(cidx) == 2'd3))
        |-> (out_data[7] &&
             out_data[4] == ($past(st) == ST_EAV) &&
             out_data[3] == (out_data[5] ^ out_data[4]) &&
             out_data[2] == (out_data[6] ^ out_data[4]) &&
             out_data[1] == (out_data[6] ^ out_data[5]) &&
             out_data[0] == (out_data[6] ^ out_data[5] ^ out_data[4])));

    assert_vbi_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_vbi |-> vld);

    assert_one_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_ready && vbi_ready));

    // a dword is only taken while a line is being sent
    assert_take_in_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_ready || vbi_ready) |-> (st == ST_DATA));

endmodule

bind ipf_formatter ipf_formatter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_gate  (cfg_gate),
    .out_data  (out_data),
    .out_qual  (out_qual),
    .out_vbi   (out_vbi),
    .vid_ready (vid_ready),
    .vbi_ready (vbi_ready),
    .vld       (q_r.ovld),
    .st        (q_r.state),
    .cidx      (q_r.cidx)
);

// File: tb/ipf_formatter_test.sv
module ipf_formatter_test;

    typedef logic [31:0] dq_t[$];
    typedef struct {
        logic [15:0] d;
        logic        vbi;
        logic        cont;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0, cfg_codes = 1'b1, cfg_gate = 1'b0, cfg_vbi_first = 1'b1;
    logic        vid_valid = 1'b0, vid_last = 1'b0, vid_field = 1'b0, vid_vblank = 1'b0;
    logic [31:0] vid_data = '0;
    logic        vbi_valid = 1'b0, vbi_last = 1'b0, vbi_field = 1'b0;
    logic [31:0] vbi_data = '0;
    logic        vid_ready, vbi_ready, out_qual, out_vbi;
    logic [15:0] out_data;

    int    checks = 0, fails = 0, beats = 0, cyc = 0, last_cyc = 0;
    bit    done = 0, gate_watch = 0;
    int    gate_bad = 0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    ipf_formatter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_codes(cfg_codes),
        .cfg_gate(cfg_gate), .cfg_vbi_first(cfg_vbi_first),
        .vid_valid(vid_valid), .vid_ready(vid_ready), .vid_data(vid_data),
        .vid_last(vid_last), .vid_field(vid_field), .vid_vblank(vid_vblank),
        .vbi_valid(vbi_valid), .vbi_ready(vbi_ready), .vbi_data(vbi_data),
        .vbi_last(vbi_last), .vbi_field(vbi_field),
        .out_data(out_data), .out_qual(out_qual), .out_vbi(out_vbi)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic push(input logic [15:0] d, input logic vbi, input logic cont, input string tag);
        item_t it;
        it.d = d; it.vbi = vbi; it.cont = cont; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic push_code(input logic vbi, input logic f, input logic v, input logic h);
        logic [7:0] c [4];
        c[0] = 8'hFF; c[1] = 8'h00; c[2] = 8'h00; c[3] = xy(f, v, h);
        for (int i = 0; i < 4; i++)
            push(cfg_wide ? {c[i], c[i]} : {8'h00, c[i]}, vbi, i != 0,
                 (i == 3) ? "R6" : (vbi ? "R11" : "R5"));
    endtask

    task automatic push_line(input logic vbi, input logic f, input logic v,
                             input dq_t dws, input string tag_ovr);
        string t;
        t = (tag_ovr != "") ? tag_ovr : (vbi ? "R11" : (cfg_wide ? "R2" : "R1"));
        if (cfg_codes) push_code(vbi, f, v, 1'b0);
        foreach (dws[k]) begin
            if (cfg_wide) begin
                push(dws[k][15:0], vbi, 1'b0, t);
                push(dws[k][31:16], vbi, 1'b1, t);
            end else begin
                for (int b = 0; b < 4; b++)
                    push({8'h00, dws[k][8*b +: 8]}, vbi, b != 0, t);
            end
        end
        if (cfg_codes) push_code(vbi, f, v, 1'b1);
    endtask

    // drivers: called at a falling edge
    task automatic send_vid(input dq_t dws, input logic f, input logic v, input int gap);
        bit acc;
        foreach (dws[k]) begin
            vid_valid = 1'b1; vid_data = dws[k]; vid_last = (k == dws.size() - 1);
            vid_field = f; vid_vblank = v;
            acc = 0;
            while (!acc) begin #1; acc = vid_ready; @(negedge clk); end
            vid_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        vid_valid = 1'b0; vid_last = 1'b0;
    endtask

    task automatic send_vbi(input dq_t dws, input logic f, input int gap);
        bit acc;
        foreach (dws[k]) begin
            vbi_valid = 1'b1; vbi_data = dws[k]; vbi_last = (k == dws.size() - 1);
            vbi_field = f;
            acc = 0;
            while (!acc) begin #1; acc = vbi_ready; @(negedge clk); end
            vbi_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        vbi_valid = 1'b0; vbi_last = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // scoreboard monitor, sampling with the clock high
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            cyc++;
            if (out_qual) begin
                beats++;
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "unexpected qualified beat", {16'h0, out_data}, 32'h0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(out_data == it.d, it.tag, "data beat", {16'h0, out_data}, {16'h0, it.d});
                    chk(out_vbi == it.vbi, "R11", "vbi flag", {31'h0, out_vbi}, {31'h0, it.vbi});
                    if (it.cont)
                        chk(cyc == last_cyc + 1, (it.tag == "R6" || it.tag == "R5") ? "R7" : "R12",
                            "beat not contiguous", cyc, last_cyc + 1);
                end
                last_cyc = cyc;
            end else begin
                chk(out_data == 16'h0, "R3", "filler on idle cycle", {16'h0, out_data}, 32'h0);
            end
        end
    end

    // gated-clock low phase watch
    always @(negedge clk) begin
        #1;
        if (gate_watch && out_qual) gate_bad++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "WD", "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        dq_t a, b;
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_qual == 1'b0, "R3", "reset qualifier", {31'h0, out_qual}, 0);
        chk(out_data == 16'h0, "R3", "reset data", {16'h0, out_data}, 0);
        chk(vid_ready == 1'b0 && vbi_ready == 1'b0, "R12", "reset ready", {30'h0, vid_ready, vbi_ready}, 0);
        chk(out_vbi == 1'b0, "R11", "reset vbi flag", {31'h0, out_vbi}, 0);

        // R8: codes enabled, no producer, no beats
        snap = beats;
        repeat (20) @(negedge clk);
        chk(beats == snap, "R8", "beats while idle", beats, snap);

        // R1 R5 R6: narrow line of three dwords
        a = '{32'h44332211, 32'h88776655, 32'hCCBBAA99};
        push_line(1'b0, 1'b0, 1'b0, a, "");
        send_vid(a, 1'b0, 1'b0, 0);
        drain();

        // R9 R12: one-dword line, then five dwords with gaps, field 1, blanking
        snap = beats;
        a = '{32'hDEADBEEF};
        push_line(1'b0, 1'b1, 1'b0, a, "R9");
        send_vid(a, 1'b1, 1'b0, 0);
        drain();
        chk(beats - snap == 12, "R9", "beats for one-dword line", beats - snap, 12);
        snap = beats;
        a = '{32'h03020100, 32'h07060504, 32'h0B0A0908, 32'h0F0E0D0C, 32'h13121110};
        push_line(1'b0, 1'b1, 1'b1, a, "R12");
        send_vid(a, 1'b1, 1'b1, 3);
        drain();
        chk(beats - snap == 28, "R9", "beats for five-dword line", beats - snap, 28);

        // R2 R5: wide bus
        cfg_wide = 1'b1;
        a = '{32'hA1B2C3D4, 32'h5566E7F8};
        push_line(1'b0, 1'b0, 1'b1, a, "");
        send_vid(a, 1'b0, 1'b1, 1);
        drain();

        // R11: VBI line on the wide bus
        a = '{32'h11111111, 32'h2A2B2C2D, 32'hF0E1D2C3};
        push_line(1'b1, 1'b1, 1'b1, a, "");
        send_vbi(a, 1'b1, 0);
        drain();
        cfg_wide = 1'b0;

        // R10: both offered together, VBI first
        a = '{32'h10203040, 32'h50607080};
        b = '{32'hAABBCCDD};
        cfg_vbi_first = 1'b1;
        push_line(1'b1, 1'b0, 1'b1, b, "R10");
        push_line(1'b0, 1'b0, 1'b0, a, "R10");
        fork
            send_vid(a, 1'b0, 1'b0, 0);
            send_vbi(b, 1'b0, 0);
        join
        drain();

        // R10: both offered together, video first
        cfg_vbi_first = 1'b0;
        push_line(1'b0, 1'b1, 1'b0, a, "R10");
        push_line(1'b1, 1'b1, 1'b1, b, "R10");
        fork
            send_vid(a, 1'b1, 1'b0, 0);
            send_vbi(b, 1'b1, 0);
        join
        drain();

        // R10: VBI arrives mid video line, no preemption
        cfg_vbi_first = 1'b1;
        a = '{32'h01010101, 32'h02020202, 32'h03030303};
        push_line(1'b0, 1'b0, 1'b0, a, "R10");
        push_line(1'b1, 1'b0, 1'b1, b, "R10");
        fork
            send_vid(a, 1'b0, 1'b0, 2);
            begin repeat (4) @(negedge clk); send_vbi(b, 1'b0, 0); end
        join
        drain();

        // R5: codes off, two lines back to back
        cfg_codes = 1'b0;
        a = '{32'hCAFEF00D, 32'h0BADC0DE};
        push_line(1'b0, 1'b0, 1'b0, a, "R5");
        send_vid(a, 1'b0, 1'b0, 0);
        push_line(1'b1, 1'b0, 1'b1, b, "R5");
        send_vbi(b, 1'b0, 0);
        drain();
        cfg_codes = 1'b1;

        // R4: gated clock output
        cfg_gate = 1'b1;
        gate_watch = 1;
        gate_bad = 0;
        a = '{32'h76543210, 32'hFEDCBA98};
        push_line(1'b0, 1'b1, 1'b0, a, "R4");
        send_vid(a, 1'b1, 1'b0, 1);
        drain();
        gate_watch = 0;
        chk(gate_bad == 0, "R4", "gated qualifier high in clock-low phase", gate_bad, 0);
        cfg_gate = 1'b0;

        chk(exp_q.size() == 0, "R9", "scoreboard empty at end", exp_q.size(), 0);
        report();
    end

endmodule